// File: doc/BRIEF.md
# Relocatable Memory Map Decoder

This block turns a 16-bit bus address into one chip select out of six: a debug ROM, a 512-byte control register block, a 1 KB RAM, a 768-byte EEPROM, a 32 KB flash and external memory. Each internal resource is placed by a small configuration register. When placements overlap, a fixed precedence picks the winner. Any address that no internal resource claims goes to external memory.

Four 8-bit configuration registers are written through a simple port. They set the register block base, the RAM base, the EEPROM base and enable, and a control byte. The control byte holds the flash enable, the flash half select and two wait-state (stretch) fields. In normal mode each register accepts only its first write. In special mode every write is accepted. A new value reaches the decoder one full cycle after the edge that captures the write.

For external accesses the block reports how many extra clocks to stretch. The 512 bytes just above the register block use their own stretch field. All other external space uses the general one.

Each configuration register has its own lock machine with two states. LK_OPEN is the state out of reset. The first accepted write moves it to LK_SEALED (transition "seal"). In LK_SEALED the register accepts a write only when special mode is high (transition "special rewrite", which stays in LK_SEALED).

Top module: `mmap_decoder`

## Requirements
- R1: After reset the map is as follows. Register block 0x0000–0x01FF. Register-following region 0x0200–0x03FF. RAM 0x0800–0x0BFF. EEPROM enabled at 0x0D00–0x0FFF. Flash enabled at 0x8000–0xFFFF. External stretch 3, following-region stretch 0. The configuration reset bytes are index0=0x00, index1=0x08, index2=0x01, index3=0x0F.
- R2: Overlaps resolve in this order, highest first: debug ROM, register block, RAM, EEPROM, flash, external.
- R3: For every address exactly one chip select is high, and an address claimed by no internal resource selects external memory.
- R4: The register block is 512 bytes at the start of a 2 KB block whose address bits [15:11] equal bits [7:3] of configuration index 0.
- R5: The RAM is 1 KB at the start of a 2 KB block whose address bits [15:11] equal bits [7:3] of configuration index 1.
- R6: The EEPROM covers offsets 0xD00–0xFFF of a 4 KB block whose address bits [15:12] equal bits [7:4] of configuration index 2. It is decoded only while bit 0 of index 2 is 1.
- R7: Bit 0 of configuration index 3 enables the flash. Bit 1 of index 3 places the flash at 0x8000–0xFFFF when 1 and at 0x0000–0x7FFF when 0.
- R8: While `bdm_active` is high, addresses 0xFF00–0xFFFF select the debug ROM. While it is low, the debug ROM is never selected.
- R9: When external memory is selected, `stretch` takes index3 bits [5:4] inside the register-following region and index3 bits [3:2] elsewhere. It is 0 whenever an internal resource is selected.
- R10: With `special_mode` low, a configuration register ignores every write after its first accepted one. With `special_mode` high, all writes are accepted.
- R11: A write captured at clock edge N changes the decode only from clock edge N+1 onward. The decode between edges N and N+1 still uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| special_mode | input | 1 | High lifts the write-once lock |
| bdm_active | input | 1 | Debug ROM is mapped while high |
| addr | input | 16 | Bus address to decode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Configuration register index (0 reg base, 1 RAM base, 2 EEPROM, 3 control) |
| cfg_wdata | input | 8 | Configuration write data |
| cs_bdm | output | 1 | Debug ROM select |
| cs_reg | output | 1 | Register block select |
| cs_ram | output | 1 | RAM select |
| cs_ee | output | 1 | EEPROM select |
| cs_flash | output | 1 | Flash select |
| cs_ext | output | 1 | External memory select |
| stretch | output | 2 | Extra clocks for the current access |

## Verification
The assertions take for granted that the inputs are stable and known at every rising edge. They also assume that `cfg_idx` and `cfg_wdata` are meaningful only while `cfg_we` is high. The bench drives every input on the falling edge and holds it through the next rising edge, so the decode and the write capture always see settled values. The write-once check uses `$stable` only on cycles after reset, and the bench releases reset on a falling edge, so no property looks at values from before the first edge.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int ST_W     = 2;
    localparam int NUM_CFG  = 4;
    localparam int IDX_W    = $clog2(NUM_CFG);
    localparam int NUM_SEL  = 6;

    localparam int CFG_REGBASE = 0;
    localparam int CFG_RAMBASE = 1;
    localparam int CFG_EEPROM  = 2;
    localparam int CFG_CTRL    = 3;

    // index 0 is the highest priority
    localparam int SEL_BDM   = 0;
    localparam int SEL_REG   = 1;
    localparam int SEL_RAM   = 2;
    localparam int SEL_EE    = 3;
    localparam int SEL_FLASH = 4;
    localparam int SEL_EXT   = 5;

    typedef enum logic {
        LK_OPEN,
        LK_SEALED
    } lock_state_t;

    typedef struct packed {
        logic [4:0]      reg_blk;
        logic [4:0]      ram_blk;
        logic [3:0]      ee_blk;
        logic            ee_on;
        logic            fl_on;
        logic            fl_hi;
        logic [ST_W-1:0] ext_st;
        logic [ST_W-1:0] fol_st;
    } map_cfg_t;

    function automatic logic [DATA_W-1:0] cfg_reset_value(input int idx);
        case (idx)
            CFG_REGBASE: return 8'h00;
            CFG_RAMBASE: return 8'h08;
            CFG_EEPROM:  return 8'h01;
            default:     return 8'h0F;
        endcase
    endfunction
endpackage

// File: rtl/mmap_cfg_regs.sv
module mmap_cfg_regs
    import mmap_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  special_mode,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [DATA_W-1:0]     cfg_wdata,
    output map_cfg_t              cfg_live
);
    logic [DATA_W-1:0] shadow_q [NUM_CFG];
    logic [DATA_W-1:0] active_q [NUM_CFG];

    for (genvar gi = 0; gi < NUM_CFG; gi++) begin : g_cfg
        lock_state_t lock_q, lock_d;
        logic        accept;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lock_q <= LK_OPEN;
            else        lock_q <= lock_d;
        end

        always_comb begin
            accept = 1'b0;
            lock_d = lock_q;
            unique case (lock_q)
                LK_OPEN: begin
                    if (cfg_we && (cfg_idx == IDX_W'(gi))) begin
                        accept = 1'b1;
                        lock_d = LK_SEALED;
                    end
                end
                LK_SEALED: begin
                    if (cfg_we && (cfg_idx == IDX_W'(gi)) && special_mode)
                        accept = 1'b1;
                end
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q[gi] <= cfg_reset_value(gi);
                active_q[gi] <= cfg_reset_value(gi);
            end else begin
                if (accept) shadow_q[gi] <= cfg_wdata;
                active_q[gi] <= shadow_q[gi];
            end
        end

        AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (lock_q == LK_SEALED && !special_mode && cfg_we && cfg_idx == IDX_W'(gi))
            |=> $stable(shadow_q[gi])); // R10

        AST_COMMIT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
            (accept && cfg_wdata != shadow_q[gi] && active_q[gi] == shadow_q[gi])
            |=> (active_q[gi] != shadow_q[gi])); // R11
    end

    always_comb begin
        cfg_live.reg_blk = active_q[CFG_REGBASE][7:3];
        cfg_live.ram_blk = active_q[CFG_RAMBASE][7:3];
        cfg_live.ee_blk  = active_q[CFG_EEPROM][7:4];
        cfg_live.ee_on   = active_q[CFG_EEPROM][0];
        cfg_live.fl_on   = active_q[CFG_CTRL][0];
        cfg_live.fl_hi   = active_q[CFG_CTRL][1];
        cfg_live.ext_st  = active_q[CFG_CTRL][3:2];
        cfg_live.fol_st  = active_q[CFG_CTRL][5:4];
    end
endmodule

// File: rtl/mmap_addr_match.sv
module mmap_addr_match
    import mmap_pkg::*;
(
    input  logic [ADDR_W-1:0]  addr,
    input  logic               bdm_active,
    input  map_cfg_t           cfg,
    output logic [NUM_SEL-1:0] hit,
    output logic               follow_hit
);
    always_comb begin
        hit             = '0;
        hit[SEL_BDM]    = bdm_active && (addr[15:8] == 8'hFF);
        hit[SEL_REG]    = (addr[15:11] == cfg.reg_blk) && (addr[10:9] == 2'b00);
        hit[SEL_RAM]    = (addr[15:11] == cfg.ram_blk) && !addr[10];
        hit[SEL_EE]     = cfg.ee_on && (addr[15:12] == cfg.ee_blk) && (addr[11:8] >= 4'hD);
        hit[SEL_FLASH]  = cfg.fl_on && (addr[15] == cfg.fl_hi);
        hit[SEL_EXT]    = 1'b1;
        follow_hit      = (addr[15:11] == cfg.reg_blk) && (addr[10:9] == 2'b01);
    end
endmodule

// File: rtl/mmap_prio_sel.sv
module mmap_prio_sel
    import mmap_pkg::*;
(
    input  logic [NUM_SEL-1:0] hit,
    input  logic               follow_hit,
    input  logic [ST_W-1:0]    ext_st,
    input  logic [ST_W-1:0]    fol_st,
    output logic [NUM_SEL-1:0] grant,
    output logic [ST_W-1:0]    stretch
);
    logic [NUM_SEL:0] taken;
    assign taken[0] = 1'b0;

    for (genvar gi = 0; gi < NUM_SEL; gi++) begin : g_prio
        assign grant[gi]   = hit[gi] && !taken[gi];
        assign taken[gi+1] = taken[gi] || hit[gi];
    end

    always_comb begin
        if (grant[SEL_EXT]) stretch = follow_hit ? fol_st : ext_st;
        else                stretch = '0;
    end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        special_mode,
    input  logic        bdm_active,
    input  logic [15:0] addr,
    input  logic        cfg_we,
    input  logic [1:0]  cfg_idx,
    input  logic [7:0]  cfg_wdata,
    output logic        cs_bdm,
    output logic        cs_reg,
    output logic        cs_ram,
    output logic        cs_ee,
    output logic        cs_flash,
    output logic        cs_ext,
    output logic [1:0]  stretch
);
    map_cfg_t           cfg_live;
    logic [NUM_SEL-1:0] hit;
    logic [NUM_SEL-1:0] grant;
    logic               follow_hit;

    mmap_cfg_regs u_cfg (
        .clk          (clk),
        .rst_n        (rst_n),
        .special_mode (special_mode),
        .cfg_we       (cfg_we),
        .cfg_idx      (cfg_idx),
        .cfg_wdata    (cfg_wdata),
        .cfg_live     (cfg_live)
    );

    mmap_addr_match u_match (
        .addr       (addr),
        .bdm_active (bdm_active),
        .cfg        (cfg_live),
        .hit        (hit),
        .follow_hit (follow_hit)
    );

    mmap_prio_sel u_prio (
        .hit        (hit),
        .follow_hit (follow_hit),
        .ext_st     (cfg_live.ext_st),
        .fol_st     (cfg_live.fol_st),
        .grant      (grant),
        .stretch    (stretch)
    );

    assign cs_bdm   = grant[SEL_BDM];
    assign cs_reg   = grant[SEL_REG];
    assign cs_ram   = grant[SEL_RAM];
    assign cs_ee    = grant[SEL_EE];
    assign cs_flash = grant[SEL_FLASH];
    assign cs_ext   = grant[SEL_EXT];

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cs_bdm, cs_reg, cs_ram, cs_ee, cs_flash, cs_ext}) == 1); // R3

    AST_INTERNAL_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_ext |-> (stretch == 2'd0)); // R9

    AST_BDM_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_bdm |-> (bdm_active && addr[15:8] == 8'hFF)); // R8

    AST_BDM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (bdm_active && addr[15:8] == 8'hFF) |-> cs_bdm); // R2
endmodule

// File: tb/sim_mmap_decoder.sv
module sim_mmap_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        special_mode = 1'b0;
    logic        bdm_active = 1'b0;
    logic [15:0] addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        cs_bdm, cs_reg, cs_ram, cs_ee, cs_flash, cs_ext;
    logic [1:0]  stretch;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    mmap_decoder u0 (
        .clk(clk), .rst_n(rst_n), .special_mode(special_mode),
        .bdm_active(bdm_active), .addr(addr), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cs_bdm(cs_bdm),
        .cs_reg(cs_reg), .cs_ram(cs_ram), .cs_ee(cs_ee),
        .cs_flash(cs_flash), .cs_ext(cs_ext), .stretch(stretch)
    );

    // behavioural reference model
    int m_reg, m_ram, m_eeb, m_een, m_fen, m_fhi, m_xs, m_fs;
    bit m_sealed [4];
    int pend_q [$];

    task automatic m_apply(input int idx, input int d);
        case (idx)
            0: m_reg = d / 8;
            1: m_ram = d / 8;
            2: begin m_eeb = d / 16; m_een = d % 2; end
            default: begin
                m_fen = d % 2; m_fhi = (d / 2) % 2;
                m_xs = (d / 4) % 4; m_fs = (d / 16) % 4;
            end
        endcase
    endtask

    task automatic m_reset();
        m_apply(0, 8'h00); m_apply(1, 8'h08); m_apply(2, 8'h01); m_apply(3, 8'h0F);
        for (int i = 0; i < 4; i++) m_sealed[i] = 0;
        pend_q.delete();
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) m_reset();
        else begin
            while (pend_q.size() > 0) begin
                int w;
                w = pend_q.pop_front();
                m_apply(w / 256, w % 256);
            end
            if (cfg_we && (!m_sealed[cfg_idx] || special_mode)) begin
                m_sealed[cfg_idx] = 1;
                pend_q.push_back(int'(cfg_idx) * 256 + int'(cfg_wdata));
            end
        end
    end

    function automatic logic [5:0] exp_cs(input int a);
        int rb, mb, eb;
        rb = m_reg * 2048; mb = m_ram * 2048; eb = m_eeb * 4096;
        if (bdm_active && a >= 'hFF00) return 6'b100000;
        if (a >= rb && a < rb + 512) return 6'b010000;
        if (a >= mb && a < mb + 1024) return 6'b001000;
        if (m_een == 1 && a >= eb + 'hD00 && a < eb + 4096) return 6'b000100;
        if (m_fen == 1 && (a / 32768) == m_fhi) return 6'b000010;
        return 6'b000001;
    endfunction

    function automatic int exp_st(input int a);
        int rb;
        rb = m_reg * 2048;
        if (exp_cs(a) != 6'b000001) return 0;
        if (a >= rb + 512 && a < rb + 1024) return m_fs;
        return m_xs;
    endfunction

    task automatic step(input logic [15:0] a, input logic we, input logic [1:0] idx,
                        input logic [7:0] d, input string tag);
        logic [5:0] ecs, acs;
        int est;
        @(negedge clk);
        addr = a; cfg_we = we; cfg_idx = idx; cfg_wdata = d;
        #1;
        ecs = exp_cs(int'(a));
        est = exp_st(int'(a));
        acs = {cs_bdm, cs_reg, cs_ram, cs_ee, cs_flash, cs_ext};
        n_tests++;
        if (acs !== ecs || int'(stretch) != est) begin
            n_fail++;
            $display("FAIL %s addr=%h cs actual=%b expected=%b stretch actual=%0d expected=%0d",
                     tag, a, acs, ecs, stretch, est);
        end
    endtask

    task automatic probe(input logic [15:0] a, input string tag);
        step(a, 1'b0, 2'd0, 8'h00, tag);
    endtask

    task automatic wr(input logic [1:0] idx, input logic [7:0] d, input string tag);
        step(16'h4000, 1'b1, idx, d, tag);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset map, R3 external fallback
        probe(16'h0000, "R1"); probe(16'h01FF, "R1"); probe(16'h0200, "R9");
        probe(16'h03FF, "R9"); probe(16'h0400, "R3"); probe(16'h0800, "R1");
        probe(16'h0BFF, "R1"); probe(16'h0C00, "R3"); probe(16'h0CFF, "R6");
        probe(16'h0D00, "R6"); probe(16'h0FFF, "R6"); probe(16'h1000, "R3");
        probe(16'h7FFF, "R9"); probe(16'h8000, "R7"); probe(16'hFFFF, "R7");
        // R8 debug ROM over flash
        bdm_active = 1'b1;
        probe(16'hFF00, "R8"); probe(16'hFEFF, "R8"); probe(16'hFFFF, "R2");
        bdm_active = 1'b0;
        probe(16'hFF00, "R8");
        // R11 control write: flash low half, ext stretch 2, follow stretch 1
        wr(2'd3, 8'h19, "R11");
        probe(16'h4000, "R11");   // old map still active
        probe(16'h4000, "R7");    // new map
        probe(16'h9000, "R9");
        probe(16'h0300, "R9");
        // R10 second write in normal mode ignored
        wr(2'd3, 8'h03, "R10");
        probe(16'h9000, "R10"); probe(16'h9000, "R10"); probe(16'h0300, "R10");
        // R4 register block moved onto RAM, R2 register wins
        wr(2'd0, 8'h08, "R4");
        probe(16'h0800, "R4"); probe(16'h0800, "R2"); probe(16'h0A00, "R2");
        probe(16'h0000, "R7"); probe(16'h09FF, "R4");
        // R6 EEPROM moved into flash range, EEPROM beats flash
        wr(2'd2, 8'h21, "R6");
        probe(16'h2000, "R6"); probe(16'h2D00, "R6"); probe(16'h2CFF, "R2");
        wr(2'd2, 8'h20, "R10");
        probe(16'h2D00, "R10"); probe(16'h2D00, "R10");
        // special mode rewrites
        special_mode = 1'b1;
        wr(2'd2, 8'h20, "R10");
        probe(16'h2D00, "R10"); probe(16'h2D00, "R6");
        wr(2'd3, 8'h00, "R7");
        probe(16'h0000, "R7"); probe(16'h0000, "R7"); probe(16'h9000, "R9");
        wr(2'd3, 8'h2C, "R9");
        wr(2'd1, 8'h30, "R5");
        probe(16'h0A00, "R9"); probe(16'h0BFF, "R9"); probe(16'h5000, "R9");
        probe(16'h3000, "R5"); probe(16'h33FF, "R5"); probe(16'h3400, "R5");
        probe(16'h0800, "R4");
        // back-to-back writes, each lags by one edge
        wr(2'd1, 8'h00, "R11");
        wr(2'd0, 8'h50, "R11");
        probe(16'h0000, "R11"); probe(16'h5000, "R11"); probe(16'h0800, "R3");
        special_mode = 1'b0;
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule